// File: doc/BRIEF.md
# Boot Image Validation Sequencer

After reset is released, this block decides where the processor goes next: to the user image held in nonvolatile memory, or into a serial programming mode. It looks first at a flag that records whether the last reset came from the watchdog. When that flag is clear, it waits a fixed number of system clocks and then samples an active-low programming-request pin. A configuration bit can turn that sampling off, and the pin then counts as not asserted.

If the pin does not select programming mode, the block reads the first eight 32-bit words of nonvolatile memory. It reads them one at a time through a simple request/response port and adds them with 32-bit wrap-around. A total of zero marks the image as valid, and the block raises the user-start output. Any other total raises the programming-mode output. Whichever output is chosen stays high until the next reset.

Top module: `boot_image_check`

## Requirements
- R1: While reset is held, and until a decision is made, `run_user` and `enter_prog` are both low. During reset `mem_req` is also low.
- R2: When `wdt_flag` is 1 at the first clock after reset, the request pin is ignored and the block goes straight to reading memory.
- R3: With `wdt_flag` and `pin_sample_off` both 0, the pin is sampled at the clock edge WAIT_CYCLES cycles after the first post-reset edge. A low level raises `enter_prog` at that edge, and no memory is read.
- R4: With sampling enabled, a high pin level at the sampling edge leads to image validation.
- R5: When `pin_sample_off` is 1, the pin is treated as high and validation starts with no delay.
- R6: When the 32-bit wrap-around sum of words 0 to 7 is zero, `run_user` is raised.
- R7: When that sum is nonzero, `enter_prog` is raised.
- R8: The words are requested in the order 0, 1, ..., 7 by word index on `mem_addr`. Each request is a one-cycle `mem_req` pulse. Only one request is outstanding at a time, and the next request follows the cycle after `mem_rvalid`.
- R9: Exactly one of `run_user` and `enter_prog` goes high. It stays high, with no further memory requests, until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdt_flag | input | 1 | Last reset was a watchdog overflow |
| pin_sample_off | input | 1 | Disable sampling of the request pin |
| prog_req_n | input | 1 | Programming-request pin, low = request |
| mem_req | output | 1 | Read strobe to nonvolatile memory |
| mem_addr | output | 3 | Word index of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| run_user | output | 1 | Start the user image |
| enter_prog | output | 1 | Enter programming mode |

## Verification
Count edges from the first rising edge after reset is released. With L the number of cycles from a request to its response, the decision appears after edge 1+W when the pin requests programming. It appears after edge 2+8(1+L) when validation starts at once, and after edge 2+W+8(1+L) when validation follows a pin sample. The bench computes that edge for each case and stores it in the scoreboard item. The monitor compares it with the edge count at the falling edge where the first output shows. A late or early decision is therefore a miscompare, even when the right output wins.

// File: rtl/boot_image_check.sv
module boot_image_check #(
  parameter int WAIT_CYCLES = 36000,
  parameter int DATA_W      = 32,
  parameter int NUM_WORDS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_flag,
  input  logic              pin_sample_off,
  input  logic              prog_req_n,
  output logic              mem_req,
  output logic [2:0]        mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              run_user,
  output logic              enter_prog
);
  localparam int AW = $clog2(NUM_WORDS);
  localparam int CW = $clog2(WAIT_CYCLES + 1);

  typedef enum logic [2:0] {
    S_START, S_WAIT, S_FETCH, S_AWAIT, S_DECIDE, S_USER, S_PROG
  } state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [AW-1:0]     idx;
  logic [DATA_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_START;
      cnt   <= '0;
      idx   <= '0;
      sum   <= '0;
    end else begin
      case (state)
        S_START:  state <= (wdt_flag || pin_sample_off) ? S_FETCH : S_WAIT;
        S_WAIT:
          if (cnt == CW'(WAIT_CYCLES - 1)) state <= prog_req_n ? S_FETCH : S_PROG;
          else cnt <= cnt + 1'b1;
        S_FETCH:  state <= S_AWAIT;
        S_AWAIT:
          if (mem_rvalid) begin
            sum <= sum + mem_rdata;
            if (idx == AW'(NUM_WORDS - 1)) state <= S_DECIDE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end
        S_DECIDE: state <= (sum == '0) ? S_USER : S_PROG;
        default:  state <= state;
      endcase
    end
  end

  assign mem_req    = (state == S_FETCH);
  assign mem_addr   = 3'(idx);
  assign run_user   = (state == S_USER);
  assign enter_prog = (state == S_PROG);

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_user && enter_prog));
  assert_user_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_user |=> run_user);
  assert_prog_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_prog |=> enter_prog);
  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_quiet_after_decision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_user || enter_prog) |-> !mem_req);
  assert_addr_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !$past(mem_rvalid)) |=> $stable(mem_addr));
endmodule

// File: tb/boot_image_check_bench.sv
module boot_image_check_bench;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_flag = 1'b0, pin_sample_off = 1'b0, prog_req_n = 1'b1;
  logic mem_req, mem_rvalid = 1'b0;
  logic [2:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic run_user, enter_prog;

  always #2 clk = ~clk;

  boot_image_check #(.WAIT_CYCLES(W)) u_boot_image_check (
    .clk(clk), .rst_n(rst_n), .wdt_flag(wdt_flag), .pin_sample_off(pin_sample_off),
    .prog_req_n(prog_req_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .run_user(run_user), .enter_prog(enter_prog));

  typedef struct { bit user; int edge_no; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  int ecnt = 0;
  int lat = 1;
  int rsp_cnt = 0;
  int exp_idx = 0;
  logic [31:0] img [8];
  bit got = 0;
  bit finished = 0;

  always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : 0;

  // memory model, drives away from the active edge
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (!rst_n) begin
      rsp_cnt = 0;
      exp_idx = 0;
    end else begin
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = img[mem_addr];
        end
      end
      if (mem_req) begin
        checks++;
        if (int'(mem_addr) != exp_idx || rsp_cnt != 0) begin
          fails++;
          $display("FAIL R8 read order: addr %0d expected %0d (pending %0d)", mem_addr, exp_idx, rsp_cnt);
        end
        exp_idx++;
        rsp_cnt = lat;
      end
    end
  end

  // monitor: pops the scoreboard when a decision appears
  always @(negedge clk) begin
    if (rst_n && !got && (run_user || enter_prog)) begin
      exp_t e;
      got = 1;
      e = q.pop_front();
      checks++;
      if (run_user != e.user || enter_prog != !e.user) begin
        fails++;
        $display("FAIL %s outcome: user=%0b prog=%0b expected user=%0b", e.tag, run_user, enter_prog, e.user);
      end
      checks++;
      if (ecnt != e.edge_no) begin
        fails++;
        $display("FAIL %s decision edge: %0d expected %0d", e.tag, ecnt, e.edge_no);
      end
    end
  end

  task automatic run(input bit wdt, input bit dis, input bit pin, input int l,
                     input bit valid, input int seed, input bit exp_user,
                     input int exp_edge, input string tag);
    logic [31:0] s;
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0;
    got = 0;
    wdt_flag = wdt; pin_sample_off = dis; prog_req_n = pin; lat = l;
    s = '0;
    for (int i = 0; i < 7; i++) begin
      img[i] = 32'(seed * (i + 1)) * 32'h9E3779B9 + 32'hF0000000;
      s = s + img[i];
    end
    img[7] = valid ? -s : (-s + 32'd1);
    repeat (3) @(negedge clk);
    checks++;
    if (run_user || enter_prog || mem_req) begin
      fails++;
      $display("FAIL R1 reset state: user=%0b prog=%0b req=%0b expected 0 0 0", run_user, enter_prog, mem_req);
    end
    e.user = exp_user; e.edge_no = exp_edge; e.tag = tag;
    q.push_back(e);
    rst_n = 1'b1;
    wait (got);
    repeat (3) @(negedge clk);
    prog_req_n = ~prog_req_n;
    wdt_flag = ~wdt_flag;
    repeat (8) @(negedge clk);
    checks++;
    if (run_user != exp_user || enter_prog != !exp_user || mem_req) begin
      fails++;
      $display("FAIL R9 hold: user=%0b prog=%0b req=%0b expected user=%0b req=0", run_user, enter_prog, mem_req, exp_user);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    run(1, 0, 0, 1, 1, 3, 1, 2 + 8 * 2, "R2 R6 watchdog valid");
    run(0, 0, 0, 1, 1, 5, 0, 1 + W, "R3 pin low");
    run(0, 0, 1, 3, 1, 7, 1, 2 + W + 8 * 4, "R4 R6 pin high valid");
    run(0, 0, 1, 2, 0, 9, 0, 2 + W + 8 * 3, "R7 pin high invalid");
    run(0, 1, 0, 1, 1, 11, 1, 2 + 8 * 2, "R5 sampling off");
    run(1, 0, 0, 2, 0, 13, 0, 2 + 8 * 3, "R2 R7 watchdog invalid");
    report();
  end

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end
endmodule